// File: doc/BRIEF.md
# Halving Tree Sum Reduction Engine

The engine keeps one partial sum for each of a fixed number of slots and folds them into a single 32-bit total. It does this in synchronized rounds, and each round roughly halves the number of active slots. Software-free control is minimal. Partial sums are written by index through a load port while the engine is idle. A start pulse launches the reduction, a busy flag covers the rounds, and a one-cycle done pulse marks the moment the total appears on the result output.

Two folding rules are available, chosen by a mode input that is sampled at start.

- **Shared-memory rule (mode 0).** If the active count is odd, slot 0 first picks up the stranded top element. The count is then halved with rounding down, and each low slot absorbs its partner one half-width above it.
- **Message-passing rule (mode 1).** The count is first halved with rounding up. The slots from the new count up to the sender limit pass their values down by that count, and slots below half the old limit accumulate what they receive.

All additions of one round use the values registered at the start of that round and complete in a single clock cycle. This makes every round a barrier. The reduction is destructive: the slot contents must be reloaded before the next run.

Top module: `hred_engine`

## Requirements
- R1: After reset, busy, done and result are all 0.
- R2: A load with ld_en high writes ld_val into slot ld_idx only while busy is low and ld_idx < NSLOT. Loads while busy, or with an index of NSLOT or more, change no slot and so do not alter the next total.
- R3: A start pulse while idle raises busy on the next cycle. A start pulse while busy is ignored and does not restart or lengthen the run.
- R4: In mode 0, the slot count C goes from NSLOT to 1, one round per clock. Each round: if C is odd, slot 0 adds slot C-1; then C becomes floor(C/2); then every slot i < C adds slot i+C. For NSLOT = 100 this takes 6 rounds.
- R5: In mode 1, each round sets C to ceil(C/2). Slots i with C <= i < limit send to slot i-C, and slots i < limit/2 (rounded down) add the value received. The limit then becomes C. For NSLOT = 100 this takes 7 rounds.
- R6: The result equals the sum of all NSLOT slots modulo 2^32 (two's-complement wraparound, no saturation).
- R7: done is high for exactly one cycle, in the same cycle in which busy first reads low after a run. The number of busy cycles equals the round count of the selected mode.
- R8: result changes only in the cycle in which done is high, and holds its value otherwise, including across later loads.
- R9: The mode is sampled with the accepted start. Changes of the mode input during a run have no effect on the round count or the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Load strobe for one partial sum |
| ld_idx | input | IDXW (7) | Slot index of the load |
| ld_val | input | W (32) | Partial sum to store |
| start | input | 1 | Start pulse for a reduction |
| mode | input | 1 | 0 = shared-memory halving, 1 = message-passing halving |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle pulse when the total is ready |
| result | output | W (32) | Held total of the last completed reduction |

## Verification
The bound checker watches the following properties on every cycle:
- the active count strictly shrinking from round to round and never reaching 1 while busy;
- busy rising only after a start;
- the mode staying frozen during a run;
- the done pulse being single and lined up with the fall of busy;
- the result staying still outside done.

The following can only be shown by the bench scenarios, because they need a known set of loaded values:
- the correctness of the total under each folding rule, including the odd-count absorb into slot 0 and the ceiling split;
- wraparound;
- the exact round count per mode;
- the rejection of loads made during a run or to out-of-range indices.

// File: rtl/hred_pkg.sv
package hred_pkg;

  // Folding rule applied by every round of one run.
  typedef enum logic {
    RED_SHARED = 1'b0,  // odd top absorbed by slot 0, floor halving
    RED_MSG    = 1'b1   // ceiling halving, senders below the limit
  } red_mode_e;

endpackage

// File: rtl/hred_rst_sync.sv
module hred_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;

  // Assert asynchronously, release after two clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= {stg_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/hred_ctrl.sv
module hred_ctrl
  import hred_pkg::*;
#(
  parameter int NSLOT = 100,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  red_mode_e     mode_in,
  output logic          busy,
  output logic          done,
  output logic          last,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] lim,
  output logic [CW-1:0] half,
  output red_mode_e     mode_q
);

  localparam logic [CW-1:0] FULL = CW'(NSLOT);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;
  red_mode_e     mode_d, mode_r;
  logic [CW:0]   cnt_up;

  // Count after the coming round, per folding rule.
  always_comb begin
    cnt_up = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
    if (mode_r == RED_MSG) begin
      half = cnt_up[CW:1];
    end else begin
      half = cnt_q >> 1;
    end
  end

  assign last = busy_q && (half <= CW'(1));

  // Next-state process.
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    mode_d = mode_r;
    if (busy_q) begin
      cnt_d = half;
      lim_d = half;
      if (half <= CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = FULL;
      lim_d  = FULL;
      mode_d = mode_in;
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
      mode_r <= RED_SHARED;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      mode_r <= mode_d;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign cnt    = cnt_q;
  assign lim    = lim_q;
  assign mode_q = mode_r;

endmodule

// File: rtl/hred_round.sv
module hred_round
  import hred_pkg::*;
#(
  parameter int NSLOT = 100,
  parameter int W     = 32,
  parameter int CW    = 7,
  parameter int IDXW  = 7
) (
  input  logic [NSLOT-1:0][W-1:0] cur,
  input  logic [CW-1:0]           cnt,
  input  logic [CW-1:0]           lim,
  input  logic [CW-1:0]           half,
  input  red_mode_e               mode,
  output logic [NSLOT-1:0][W-1:0] nxt
);

  // Under either rule no slot at or above NSLOT/2 ever receives.
  localparam int RCV = NSLOT / 2;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i < RCV) begin : g_rcv
      logic          take;
      logic [CW:0]   part;
      logic [W-1:0]  pval;
      logic [W-1:0]  xval;

      // Partner one new-count above, if this slot is a receiver.
      always_comb begin
        if (mode == RED_MSG) begin
          take = CW'(i) < (lim >> 1);
        end else begin
          take = CW'(i) < half;
        end
        part = (CW+1)'(i) + {1'b0, half};
        pval = '0;
        if (take && (part < (CW+1)'(NSLOT))) begin
          pval = cur[part[IDXW-1:0]];
        end
      end

      if (i == 0) begin : g_odd
        logic [CW-1:0] top;
        // Stranded top element of an odd count goes to slot 0.
        always_comb begin
          top  = cnt - CW'(1);
          xval = '0;
          if ((mode == RED_SHARED) && cnt[0] && (top < CW'(NSLOT))) begin
            xval = cur[top[IDXW-1:0]];
          end
        end
      end else begin : g_even
        assign xval = '0;
      end

      assign nxt[i] = cur[i] + pval + xval;
    end else begin : g_pass
      assign nxt[i] = cur[i];
    end
  end

endmodule

// File: rtl/hred_bank.sv
module hred_bank #(
  parameter int NSLOT = 100,
  parameter int W     = 32,
  parameter int IDXW  = 7
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IDXW-1:0]         wr_idx,
  input  logic [W-1:0]            wr_val,
  input  logic                    rnd_en,
  input  logic [NSLOT-1:0][W-1:0] rnd_val,
  output logic [NSLOT-1:0][W-1:0] slots
);

  localparam int RCV = NSLOT / 2;

  for (genvar i = 0; i < NSLOT; i++) begin : g_cell
    logic         en;
    logic [W-1:0] d;
    logic [W-1:0] q;

    // Clock enable: round update for receiver slots, else an addressed load.
    always_comb begin
      if (rnd_en) begin
        en = (i < RCV);
        d  = rnd_val[i];
      end else begin
        en = wr_en && (wr_idx == IDXW'(i));
        d  = wr_val;
      end
    end

    // Data storage carries no reset; contents are defined by loads.
    always_ff @(posedge clk) begin
      if (en) begin
        q <= d;
      end
    end

    assign slots[i] = q;
  end

endmodule

// File: rtl/hred_engine.sv
module hred_engine
  import hred_pkg::*;
#(
  parameter  int NSLOT = 100,
  parameter  int W     = 32,
  localparam int IDXW  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW    = $clog2(NSLOT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [IDXW-1:0] ld_idx,
  input  logic [W-1:0]    ld_val,
  input  logic            start,
  input  logic            mode,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    result
);

  logic                    rst_sync_n;
  logic                    last;
  logic                    ld_ok;
  logic [CW-1:0]           cnt_q;
  logic [CW-1:0]           lim_q;
  logic [CW-1:0]           half;
  red_mode_e               mode_q;
  logic [NSLOT-1:0][W-1:0] slots;
  logic [NSLOT-1:0][W-1:0] nxt;
  logic [W-1:0]            res_q;

  hred_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hred_ctrl #(.NSLOT(NSLOT), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .mode_in (red_mode_e'(mode)),
    .busy    (busy),
    .done    (done),
    .last    (last),
    .cnt     (cnt_q),
    .lim     (lim_q),
    .half    (half),
    .mode_q  (mode_q)
  );

  // Loads are accepted only while idle and in range.
  assign ld_ok = ld_en && !busy && ({1'b0, ld_idx} < (IDXW+1)'(NSLOT));

  hred_bank #(.NSLOT(NSLOT), .W(W), .IDXW(IDXW)) u_bank (
    .clk     (clk),
    .wr_en   (ld_ok),
    .wr_idx  (ld_idx),
    .wr_val  (ld_val),
    .rnd_en  (busy),
    .rnd_val (nxt),
    .slots   (slots)
  );

  hred_round #(.NSLOT(NSLOT), .W(W), .CW(CW), .IDXW(IDXW)) u_round (
    .cur  (slots),
    .cnt  (cnt_q),
    .lim  (lim_q),
    .half (half),
    .mode (mode_q),
    .nxt  (nxt)
  );

  // Total captured on the final round only.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
    end else if (last) begin
      res_q <= nxt[0];
    end
  end

  assign result = res_q;

endmodule

// File: rtl/hred_chk.sv
module hred_chk
  import hred_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  result,
  input logic [CW-1:0] cnt,
  input red_mode_e     mode_q
);

  assert_busy_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3/R4: a restart would raise the count again
  assert_count_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cnt < $past(cnt)));

  assert_count_above_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt > CW'(1)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));

endmodule

bind hred_engine hred_chk #(.W(W), .CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result),
  .cnt    (cnt_q),
  .mode_q (mode_q)
);

// File: tb/sim_hred_engine.sv
module sim_hred_engine;

  localparam int N  = 100;
  localparam int W  = 32;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_en;
  logic [IW-1:0] ld_idx;
  logic [W-1:0]  ld_val;
  logic          start;
  logic          mode;
  logic          busy;
  logic          done;
  logic [W-1:0]  result;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hred_engine #(.NSLOT(N), .W(W)) u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (ld_en),
    .ld_idx (ld_idx),
    .ld_val (ld_val),
    .start  (start),
    .mode   (mode),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  task automatic check_eq(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Rounds needed per R4 (mode 0) and R5 (mode 1).
  function automatic int exp_rounds(input logic md);
    int c = N;
    int r = 0;
    while (c > 1) begin
      c = md ? (c + 1) / 2 : c / 2;
      r++;
    end
    return r;
  endfunction

  task automatic load_one(input int idx, input logic [W-1:0] v);
    ld_en  = 1'b1;
    ld_idx = IW'(idx);
    ld_val = v;
    @(negedge clk);
    ld_en  = 1'b0;
  endtask

  // Load every slot with a pattern; return the wrapped total (R6).
  task automatic load_pattern(input int kind, output logic [W-1:0] sum);
    logic [W-1:0] v;
    sum = '0;
    for (int i = 0; i < N; i++) begin
      case (kind)
        0:       v = W'(i + 1);
        1:       v = 32'hFFFF_FFF0 + W'(i);
        2:       v = (i % 2 == 1) ? -W'(i * 7) : W'(i * 13);
        3:       v = (i == 24) ? 32'h0000_0055 : '0;
        default: v = (i == 12) ? 32'h0000_0ABC : '0;
      endcase
      load_one(i, v);
      sum = sum + v;
    end
  endtask

  // inj: 0 none, 1 start while busy, 2 mode flip, 3 load while busy
  task automatic run_case(input string tag, input logic md, input int inj, input logic [W-1:0] exp_sum);
    int k   = exp_rounds(md);
    int cyc = 0;
    start = 1'b1;
    mode  = md;
    @(negedge clk);
    start = 1'b0;
    check_eq({tag, " R3 busy after start"}, W'(busy), 1);
    while (!done && cyc < 500) begin
      if (cyc == 1) begin
        case (inj)
          1: start = 1'b1;
          2: mode  = ~md;
          3: begin ld_en = 1'b1; ld_idx = IW'(3); ld_val = 32'h0000_1000; end
          default: ;
        endcase
      end
      @(negedge clk);
      cyc++;
      start = 1'b0;
      ld_en = 1'b0;
    end
    check_eq({tag, md ? " R5 round count" : " R4 round count"}, W'(cyc), W'(k));
    check_eq({tag, " R7 busy low with done"}, W'(busy), 0);
    check_eq({tag, " R6 total"}, result, exp_sum);
    @(negedge clk);
    check_eq({tag, " R7 done single cycle"}, W'(done), 0);
    check_eq({tag, " R8 result held"}, result, exp_sum);
    mode = 1'b0;
  endtask

  task automatic t_reset();
    check_eq("R1 busy after reset", W'(busy), 0);
    check_eq("R1 done after reset", W'(done), 0);
    check_eq("R1 result after reset", result, 0);
  endtask

  task automatic t_shared_basic();
    logic [W-1:0] s;
    load_pattern(0, s);
    check_eq("R6 bench sum of 1..N", s, 32'd5050);
    run_case("shared ramp", 1'b0, 0, s);
  endtask

  task automatic t_msg_basic();
    logic [W-1:0] s;
    load_pattern(0, s);
    run_case("msg ramp", 1'b1, 0, s);
  endtask

  task automatic t_wrap();
    logic [W-1:0] s;
    load_pattern(1, s);
    run_case("wrap R6", 1'b0, 0, s);
  endtask

  task automatic t_mixed_msg();
    logic [W-1:0] s;
    load_pattern(2, s);
    run_case("mixed sign msg", 1'b1, 0, s);
  endtask

  task automatic t_odd_absorb();
    logic [W-1:0] s;
    load_pattern(3, s);
    run_case("odd absorb R4", 1'b0, 0, s);
  endtask

  task automatic t_ceil_split();
    logic [W-1:0] s;
    load_pattern(4, s);
    run_case("ceiling split R5", 1'b1, 0, s);
  endtask

  task automatic t_restart_ignored();
    logic [W-1:0] s;
    load_pattern(0, s);
    run_case("start while busy R3", 1'b0, 1, s);
  endtask

  task automatic t_mode_frozen();
    logic [W-1:0] s;
    load_pattern(2, s);
    run_case("mode flip R9", 1'b1, 2, s);
  endtask

  task automatic t_busy_load();
    logic [W-1:0] s;
    load_pattern(0, s);
    run_case("load while busy R2", 1'b0, 3, s);
  endtask

  task automatic t_range_load();
    logic [W-1:0] s;
    load_pattern(2, s);
    load_one(N, 32'h0BAD_0001);
    load_one((1 << IW) - 1, 32'h0BAD_0002);
    run_case("index out of range R2", 1'b0, 0, s);
  endtask

  task automatic t_hold_after();
    logic [W-1:0] s;
    load_pattern(0, s);
    run_case("hold base", 1'b1, 0, s);
    load_one(0, 32'h7777_0000);
    load_one(7, 32'h0000_7777);
    repeat (3) @(negedge clk);
    check_eq("R8 result after later loads", result, s);
    check_eq("R7 no stray done", W'(done), 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    ld_en  = 1'b0;
    ld_idx = '0;
    ld_val = '0;
    start  = 1'b0;
    mode   = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_shared_basic();
    t_msg_basic();
    t_wrap();
    t_mixed_msg();
    t_odd_absorb();
    t_ceil_split();
    t_restart_ignored();
    t_mode_frozen();
    t_busy_load();
    t_range_load();
    t_hold_after();
    report();
    $finish;
  end

endmodule